// File: doc/BRIEF.md
# Dual-Channel Serial Line Memory

The block contains two line memories that share nothing. Each one is a sequential-access store of a fixed number of words, with its own clock, its own synchronous reset, a write port and a read port. Each port walks through the store with an address counter. The counter moves on only when that port is enabled. It returns to zero in two cases: when it passes the last word, or when its clear strobe is asserted. No full or empty flags exist. The only thing that sets the spacing between the write position and the read position is the timing of the clear strobes and the enables.

The read port sends out a word that was captured at the start of its cycle. The write port stores its word at the end of the cycle. If both clears are pulsed together and both ports then run without a break, every word comes back exactly one line later. Shorter delays of n words are made in three ways: clear both sides every n cycles, clear the read side n cycles after the write side, or keep reads disabled for the first n cycles after a common clear. The read port models a three-state pin as a data bus plus a separate output-enable flag.

All strobes are active low. The clock-domain reset is synchronous and active high.

Top module: `dual_line_mem`

## Requirements
- R1: While a channel's `rst_x` is high at a rising edge, that channel's read output-enable goes low, its read data becomes 0, and both of its address counters go to address 0.
- R2: When `wr_en_n_x` is 0 at a rising edge, `wr_data_x` is stored at the current write address and the write counter advances by one.
- R3: When `wr_en_n_x` is 1 at a rising edge, no word is stored and the write counter keeps its value, whatever is on `wr_data_x`.
- R4: When `rd_en_n_x` is 0 at a rising edge, the word at the current read address appears on `rd_data_x` after that edge with `rd_oe_x` = 1, and the read counter advances by one.
- R5: When `rd_en_n_x` is 1 at a rising edge, after that edge `rd_oe_x` = 0 and `rd_data_x` = 0, and the read counter keeps its value.
- R6: When `wr_clr_n_x` is 0 at a rising edge, the write counter is set to 0. If `wr_en_n_x` is also 0, the clear takes priority: the word goes to address 0 and the counter is left at 1.
- R7: When `rd_clr_n_x` is 0 at a rising edge, the read counter is set to 0. If `rd_en_n_x` is also 0, the clear takes priority: the word at address 0 is output and the counter is left at 1.
- R8: Each counter goes from address LINE_LEN-1 back to address 0.
- R9: If the read and write addresses are the same at one edge, the read returns the word stored before that edge. A common clear followed by continuous access therefore returns each word exactly LINE_LEN edges after it was written.
- R10: The two channels have separate clocks and separate state. Reset, strobes or data on one channel have no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Channel A clock |
| rst_a | input | 1 | Channel A synchronous reset, active high |
| wr_en_n_a | input | 1 | Channel A write enable, active low |
| wr_clr_n_a | input | 1 | Channel A write counter clear, active low |
| wr_data_a | input | DATA_W | Channel A write word |
| rd_en_n_a | input | 1 | Channel A read enable, active low |
| rd_clr_n_a | input | 1 | Channel A read counter clear, active low |
| rd_data_a | output | DATA_W | Channel A read word, 0 when not driven |
| rd_oe_a | output | 1 | Channel A output drive flag (0 = high impedance) |
| clk_b | input | 1 | Channel B clock |
| rst_b | input | 1 | Channel B synchronous reset, active high |
| wr_en_n_b | input | 1 | Channel B write enable, active low |
| wr_clr_n_b | input | 1 | Channel B write counter clear, active low |
| wr_data_b | input | DATA_W | Channel B write word |
| rd_en_n_b | input | 1 | Channel B read enable, active low |
| rd_clr_n_b | input | 1 | Channel B read counter clear, active low |
| rd_data_b | output | DATA_W | Channel B read word, 0 when not driven |
| rd_oe_b | output | 1 | Channel B output drive flag (0 = high impedance) |

## Verification
The bench targets six kinds of mistake:
- A clear asserted together with an enable: a design where the enable wins would leave the counter at its old value plus one, and one where the clear wins without performing the access would leave it at 0. Either way every later word is shifted by one address.
- The moment a counter passes LINE_LEN-1: a counter that does not wrap reads words that were never written.
- A read and a write at the same address on the same edge: a design that passes the new word straight through makes the one-line delay a zero-line delay.
- Edges with writes disabled and random data on the bus: a leak corrupts the line.
- Edges with reads disabled: a design that keeps the enable flag high or still moves the counter fails here.
- Channel B running on an unrelated clock while channel A is held in reset: any coupling between the channels shows up as a mismatch on channel B.

// File: rtl/lm_pkg.sv
package lm_pkg;

  // What a port's address counter does at the coming edge
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_ZERO = 2'd1,
    PTR_STEP = 2'd2,
    PTR_ONE  = 2'd3
  } ptr_op_e;

  // The clear has priority: an access on a clear edge uses address 0
  function automatic ptr_op_e decode_op(input logic en_n, input logic clr_n);
    if (!clr_n) return en_n ? PTR_ZERO : PTR_ONE;
    return en_n ? PTR_HOLD : PTR_STEP;
  endfunction

endpackage

// File: rtl/lm_addr_ctr.sv
module lm_addr_ctr
  import lm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_n,
  input  logic          clr_n,
  output logic [AW-1:0] addr_o,
  output logic          fire_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] ONE  = (DEPTH > 1) ? AW'(1) : '0;

  logic [AW-1:0] ptr_q;
  ptr_op_e       op;

  assign op     = decode_op(en_n, clr_n);
  assign addr_o = clr_n ? ptr_q : '0;
  assign fire_o = !en_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      unique case (op)
        PTR_ZERO: ptr_q <= '0;
        PTR_ONE:  ptr_q <= ONE;
        PTR_STEP: ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

endmodule

// File: rtl/lm_store.sv
module lm_store #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual port, read-first: the read register samples the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/lm_channel.sv
module lm_channel #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_n,
  input  logic              wr_clr_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              rd_clr_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);

  logic [AW-1:0]     waddr, raddr;
  logic              wfire, rfire;
  logic [DATA_W-1:0] rword;
  logic              oe_q;

  lm_addr_ctr #(.DEPTH(DEPTH)) u_wctr (
    .clk(clk), .rst(rst), .en_n(wr_en_n), .clr_n(wr_clr_n),
    .addr_o(waddr), .fire_o(wfire)
  );

  lm_addr_ctr #(.DEPTH(DEPTH)) u_rctr (
    .clk(clk), .rst(rst), .en_n(rd_en_n), .clr_n(rd_clr_n),
    .addr_o(raddr), .fire_o(rfire)
  );

  lm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wfire && !rst), .waddr(waddr), .wdata(wr_data),
    .re(rfire && !rst), .raddr(raddr), .rdata(rword)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= rfire;
  end

  // A bus that is not driven reads as zero
  assign rd_oe   = oe_q;
  assign rd_data = oe_q ? rword : '0;

endmodule

// File: rtl/dual_line_mem.sv
module dual_line_mem #(
  parameter int DATA_W   = 4,
  parameter int LINE_LEN = 256,
  localparam int NCH = 2
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              wr_en_n_a,
  input  logic              wr_clr_n_a,
  input  logic [DATA_W-1:0] wr_data_a,
  input  logic              rd_en_n_a,
  input  logic              rd_clr_n_a,
  output logic [DATA_W-1:0] rd_data_a,
  output logic              rd_oe_a,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              wr_en_n_b,
  input  logic              wr_clr_n_b,
  input  logic [DATA_W-1:0] wr_data_b,
  input  logic              rd_en_n_b,
  input  logic              rd_clr_n_b,
  output logic [DATA_W-1:0] rd_data_b,
  output logic              rd_oe_b
);

  logic [NCH-1:0]              clk_v, rst_v, wen_v, wclr_v, ren_v, rclr_v, oe_v;
  logic [NCH-1:0][DATA_W-1:0]  wd_v, rd_v;

  assign clk_v  = {clk_b, clk_a};
  assign rst_v  = {rst_b, rst_a};
  assign wen_v  = {wr_en_n_b, wr_en_n_a};
  assign wclr_v = {wr_clr_n_b, wr_clr_n_a};
  assign ren_v  = {rd_en_n_b, rd_en_n_a};
  assign rclr_v = {rd_clr_n_b, rd_clr_n_a};
  assign wd_v   = {wr_data_b, wr_data_a};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lm_channel #(.DATA_W(DATA_W), .DEPTH(LINE_LEN)) u_ch (
      .clk(clk_v[c]), .rst(rst_v[c]),
      .wr_en_n(wen_v[c]), .wr_clr_n(wclr_v[c]), .wr_data(wd_v[c]),
      .rd_en_n(ren_v[c]), .rd_clr_n(rclr_v[c]),
      .rd_data(rd_v[c]), .rd_oe(oe_v[c])
    );
  end

  assign rd_data_a = rd_v[0];
  assign rd_oe_a   = oe_v[0];
  assign rd_data_b = rd_v[1];
  assign rd_oe_b   = oe_v[1];

endmodule

// File: rtl/dual_line_mem_chk.sv
module dual_line_mem_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk_a,
  input logic              rst_a,
  input logic              rd_en_n_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic              rd_oe_a,
  input logic              clk_b,
  input logic              rst_b,
  input logic              rd_en_n_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              rd_oe_b
);

  logic rst_seen_a, rst_seen_b;

  always_ff @(posedge clk_a) rst_seen_a <= rst_a;
  always_ff @(posedge clk_b) rst_seen_b <= rst_b;

  always @(posedge clk_a) begin
    if (rst_seen_a === 1'b1)
      AST_RST_QUIET_A: assert (!rd_oe_a && rd_data_a == '0) else $error("reset A"); // R1
  end

  always @(posedge clk_b) begin
    if (rst_seen_b === 1'b1)
      AST_RST_QUIET_B: assert (!rd_oe_b && rd_data_b == '0) else $error("reset B"); // R1
  end

  AST_RD_DRIVES_A: assert property (@(posedge clk_a) disable iff (rst_a)
    !rd_en_n_a |=> rd_oe_a) else $error("oe A"); // R4

  AST_RD_DRIVES_B: assert property (@(posedge clk_b) disable iff (rst_b)
    !rd_en_n_b |=> rd_oe_b) else $error("oe B"); // R4

  AST_RD_HIZ_A: assert property (@(posedge clk_a) disable iff (rst_a)
    rd_en_n_a |=> (!rd_oe_a && rd_data_a == '0)) else $error("hiz A"); // R5

  AST_RD_HIZ_B: assert property (@(posedge clk_b) disable iff (rst_b)
    rd_en_n_b |=> (!rd_oe_b && rd_data_b == '0)) else $error("hiz B"); // R5

endmodule

bind dual_line_mem dual_line_mem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a(clk_a), .rst_a(rst_a), .rd_en_n_a(rd_en_n_a),
  .rd_data_a(rd_data_a), .rd_oe_a(rd_oe_a),
  .clk_b(clk_b), .rst_b(rst_b), .rd_en_n_b(rd_en_n_b),
  .rd_data_b(rd_data_b), .rd_oe_b(rd_oe_b)
);

// File: tb/dual_line_mem_tb_top.sv
`timescale 1ns/1ps
module dual_line_mem_tb_top;

  localparam int DW   = 4;
  localparam int LINE = 16;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  always #2.5 clk_a = ~clk_a;   // 200 MHz
  always #3.5 clk_b = ~clk_b;   // unrelated second clock

  logic          rst [2];
  logic          wen_n [2], wclr_n [2], ren_n [2], rclr_n [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd_a, rd_b;
  logic          oe_a, oe_b;

  dual_line_mem #(.DATA_W(DW), .LINE_LEN(LINE)) dut_i (
    .clk_a(clk_a), .rst_a(rst[0]), .wr_en_n_a(wen_n[0]), .wr_clr_n_a(wclr_n[0]),
    .wr_data_a(wd[0]), .rd_en_n_a(ren_n[0]), .rd_clr_n_a(rclr_n[0]),
    .rd_data_a(rd_a), .rd_oe_a(oe_a),
    .clk_b(clk_b), .rst_b(rst[1]), .wr_en_n_b(wen_n[1]), .wr_clr_n_b(wclr_n[1]),
    .wr_data_b(wd[1]), .rd_en_n_b(ren_n[1]), .rd_clr_n_b(rclr_n[1]),
    .rd_data_b(rd_b), .rd_oe_b(oe_b)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference per channel
  int    mem_m [2][LINE];
  int    wp [2], rp [2];
  int    exp_dat [2];
  bit    exp_oe [2];
  string cur_tag [2];
  string exp_tag [2];

  task automatic model_step(input int ch);
    int a;
    exp_tag[ch] = cur_tag[ch];
    if (rst[ch]) begin
      wp[ch] = 0; rp[ch] = 0; exp_oe[ch] = 0; exp_dat[ch] = 0;
      return;
    end
    // read sees the line before this edge's write
    if (!ren_n[ch]) begin
      a = rclr_n[ch] ? rp[ch] : 0;
      exp_dat[ch] = mem_m[ch][a];
      exp_oe[ch]  = 1;
      rp[ch] = (a == LINE - 1) ? 0 : a + 1;
    end else begin
      exp_oe[ch] = 0; exp_dat[ch] = 0;
      if (!rclr_n[ch]) rp[ch] = 0;
    end
    if (!wen_n[ch]) begin
      a = wclr_n[ch] ? wp[ch] : 0;
      mem_m[ch][a] = int'(wd[ch]);
      wp[ch] = (a == LINE - 1) ? 0 : a + 1;
    end else if (!wclr_n[ch]) begin
      wp[ch] = 0;
    end
  endtask

  always @(posedge clk_a) model_step(0);
  always @(posedge clk_b) model_step(1);

  task automatic compare(input int ch);
    logic          oe;
    logic [DW-1:0] d;
    oe = (ch == 0) ? oe_a : oe_b;
    d  = (ch == 0) ? rd_a : rd_b;
    checks++;
    if (oe !== exp_oe[ch] || d !== DW'(exp_dat[ch])) begin
      fails++;
      $display("FAIL %s ch%0d: oe/data got %0b/%0h expected %0b/%0h",
               exp_tag[ch], ch, oe, d, exp_oe[ch], exp_dat[ch]);
    end
  endtask

  always @(negedge clk_a) if (!done) compare(0);
  always @(negedge clk_b) if (!done) compare(1);

  task automatic wait_neg(input int ch);
    if (ch == 0) @(negedge clk_a);
    else         @(negedge clk_b);
  endtask

  task automatic cyc(input int ch, input bit we, input bit wc, input int d,
                     input bit re, input bit rc);
    wait_neg(ch);
    wen_n[ch]  = !we;
    wclr_n[ch] = !wc;
    wd[ch]     = DW'(d);
    ren_n[ch]  = !re;
    rclr_n[ch] = !rc;
  endtask

  task automatic run_channel(input int ch);
    int hist[$];
    cur_tag[ch] = "R1";
    repeat (3) wait_neg(ch);
    rst[ch] = 0;
    // fill one line; first edge combines write clear and write
    for (int i = 0; i < LINE; i++) begin
      cur_tag[ch] = (i == 0) ? "R6" : "R2";
      cyc(ch, 1, i == 0, (i * 7 + 3 + ch * 5) & 15, 0, 0);
    end
    // read back past the end with writes disabled and noise on the data bus
    for (int i = 0; i < LINE + 4; i++) begin
      cur_tag[ch] = (i < 2) ? "R7" : (i >= LINE) ? "R8" : "R3";
      cyc(ch, 0, 0, $urandom_range(15), 1, i == 0);
    end
    // reads disabled while writing
    cur_tag[ch] = "R5";
    repeat (10) cyc(ch, 1, 0, $urandom_range(15), 0, 0);
    // random strobes, clears and enables
    cur_tag[ch] = "R4";
    for (int i = 0; i < 300; i++)
      cyc(ch, ($urandom % 4) != 0, ($urandom % 16) == 0, $urandom_range(15),
          ($urandom % 4) != 0, ($urandom % 16) == 0);
    // one-line delay after a common clear
    cur_tag[ch] = "R9";
    for (int i = 0; i < 3 * LINE; i++) begin
      int d;
      d = $urandom_range(15);
      cyc(ch, 1, i == 0, d, 1, i == 0);
      if (i >= 1 && (i - 1) >= LINE) begin
        logic [DW-1:0] got;
        got = (ch == 0) ? rd_a : rd_b;
        checks++;
        if (got !== DW'(hist[i - 1 - LINE])) begin
          fails++;
          $display("FAIL R9 ch%0d line delay: got %0h expected %0h",
                   ch, got, hist[i - 1 - LINE]);
        end
      end
      hist.push_back(d);
    end
    cyc(ch, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      rst[c] = 1; wen_n[c] = 1; wclr_n[c] = 1; ren_n[c] = 1; rclr_n[c] = 1;
      wd[c] = '0; wp[c] = 0; rp[c] = 0; exp_oe[c] = 0; exp_dat[c] = 0;
      cur_tag[c] = "R1"; exp_tag[c] = "R1";
    end
    fork
      run_channel(0);
      run_channel(1);
    join
    // channel A held in reset while B keeps running
    fork
      begin
        cur_tag[0] = "R1";
        rst[0] = 1;
        repeat (20) wait_neg(0);
        rst[0] = 0;
      end
      begin
        cur_tag[1] = "R10";
        for (int i = 0; i < 60; i++)
          cyc(1, 1, 0, $urandom_range(15), 1, 0);
      end
    join
    repeat (2) wait_neg(1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got running expected finished");
      summary();
      $finish;
    end
  end

endmodule